// File: doc/BRIEF.md
# DMA Channel Control Register Unit

This unit holds the shared control state for a four-channel DMA controller: a command byte, one mode byte per channel, a four-bit channel mask, and an eight-bit status byte. The low status nibble holds terminal-count flags and the high nibble holds request flags. A processor-side bus writes eight control ports and reads two of them. Engine-side strobes raise or drop channel requests and report terminal counts.

From the mask and the request flags the unit picks, every cycle, the lowest-numbered channel that is both unmasked and requesting. It presents that channel with a transfer length derived from the channel's base count and the transfer width. It also decodes each channel's mode byte into separate fields for the transfer engine. It keeps a byte-pointer toggle that the channel register file steps and the control ports clear.

Top module: `dmac_ctrl_unit`

## Requirements
- R1: A write to port 0 loads `cmd_value` only when the data has no bit set other than bit 2, which includes zero. Any other write to port 0 leaves the command unchanged.
- R2: A write to port 1 selects channel `wr_data[1:0]`. It sets that channel's request flag (status bit channel+4) when `wr_data[2]` is 1 and clears it when `wr_data[2]` is 0. It always clears that channel's terminal-count flag (status bit channel).
- R3: A write to port 2 sets mask bit `wr_data[1:0]` when `wr_data[2]` is 1 and clears it otherwise.
- R4: A write to port 3 stores the whole byte as the mode of channel `wr_data[1:0]`. Each channel c exports four fields: bits [3:2] on `mode_xfer[2c+1:2c]`, bit 4 on `mode_auto[c]`, bit 5 on `mode_dec[c]`, and bits [7:6] on `mode_op[2c+1:2c]`.
- R5: `ptr_step` inverts `ptr_toggle`. A write to port 4 clears `ptr_toggle`, and the clear wins over a step in the same cycle.
- R6: A write to port 5 is a master clear: toggle 0, mask 4'hF, status 0 and command 0. Mode bytes are kept.
- R7: A write to port 6 clears all mask bits. A write to port 7 loads the mask from `wr_data[3:0]`.
- R8: While `rd_en` is high, port 0 reads the status byte and port 1 reads `{4'h0, mask}`. Every other port reads 0, and `rd_data` is 0 while `rd_en` is low. A port-0 read clears status bits [3:0] at the clock edge and keeps bits [7:4].
- R9: `svc_valid` is high when some channel has its mask bit 0 and its request flag 1. `svc_chan` is then the lowest such channel.
- R10: `tc_pulse[c]` sets status bit c and clears request flag c. `req_hold[c]` sets request flag c. `req_release[c]` clears request flag c.
- R11: `svc_len` is the selected channel's base count plus 1, shifted left by one when `word_mode` is 1. It is 0 when `svc_valid` is low.
- R12: After reset the mask is 4'hF and the status, command, toggle and all mode bytes are 0.
- R13: Events in one cycle apply in this order, with later ones winning: status-read clear, control write, terminal count, hold, release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control port write strobe |
| rd_en | input | 1 | Control port read strobe |
| port_sel | input | 3 | Control port index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| req_hold | input | 4 | Per-channel request raise |
| req_release | input | 4 | Per-channel request drop |
| tc_pulse | input | 4 | Per-channel terminal-count pulse |
| ptr_step | input | 1 | Byte-pointer toggle step |
| base_cnt | input | 64 | Base count per channel, 16 bits each, channel 0 lowest |
| word_mode | input | 1 | 1 selects 16-bit transfers |
| cmd_value | output | 8 | Command register |
| ptr_toggle | output | 1 | Byte-pointer toggle |
| mode_xfer | output | 8 | Transfer-type field per channel |
| mode_auto | output | 4 | Auto-initialize bit per channel |
| mode_dec | output | 4 | Address-decrement bit per channel |
| mode_op | output | 8 | Operating-mode field per channel |
| svc_valid | output | 1 | A channel is eligible for service |
| svc_chan | output | 2 | Selected channel |
| svc_len | output | 18 | Transfer length of the selected channel |

## Verification
The assertions assume that every input is synchronous to `clk` and free of unknown values. They also assume that each strobe is valid for exactly one cycle, so one pulse on `req_hold`, `tc_pulse` or a port write stands for one event. The stimulus drives all inputs at the falling edge and gives every strobe a defined value each cycle. It deliberately overlaps hold, release, terminal count, status reads and port writes in the same cycle, so that the ordering rule is exercised rather than avoided.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH  = 4;
  localparam int CH_W = 2;

  typedef enum logic [2:0] {
    PORT_CMD    = 3'd0,
    PORT_REQ    = 3'd1,
    PORT_MSK1   = 3'd2,
    PORT_MODE   = 3'd3,
    PORT_TOGCLR = 3'd4,
    PORT_MCLR   = 3'd5,
    PORT_MSKCLR = 3'd6,
    PORT_MSKALL = 3'd7
  } ctl_port_e;

  // only this command bit may be set in an accepted command write
  localparam logic [7:0] CMD_OK_BITS = 8'h04;
endpackage

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [7:0]        wr_data,
  output logic [2*NCH-1:0]  mode_xfer,
  output logic [NCH-1:0]    mode_auto,
  output logic [NCH-1:0]    mode_dec,
  output logic [2*NCH-1:0]  mode_op
);
  logic [7:0] mode_q [NCH];
  logic [7:0] mode_n [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      mode_n[c] = mode_q[c];
      if (mode_we && (wr_data[CH_W-1:0] == CH_W'(c))) begin
        mode_n[c] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[c] <= '0;
      end else if (mode_we) begin
        mode_q[c] <= mode_n[c];
      end
    end

    assign mode_xfer[2*c +: 2] = mode_q[c][3:2];
    assign mode_auto[c]        = mode_q[c][4];
    assign mode_dec[c]         = mode_q[c][5];
    assign mode_op[2*c +: 2]   = mode_q[c][7:6];
  end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [2:0]     port_sel,
  input  logic [7:0]     wr_data,
  input  logic [NCH-1:0] req_hold,
  input  logic [NCH-1:0] req_release,
  input  logic [NCH-1:0] tc_pulse,
  input  logic           ptr_step,
  output logic [7:0]     rd_data,
  output logic [7:0]     cmd_q,
  output logic [NCH-1:0] mask_q,
  output logic [2*NCH-1:0] stat_q,
  output logic           tog_q
);
  logic [7:0]       cmd_n;
  logic [NCH-1:0]   mask_n;
  logic [2*NCH-1:0] stat_n;
  logic             tog_n;
  ctl_port_e        port;
  logic [CH_W-1:0]  ch;

  assign port = ctl_port_e'(port_sel);
  assign ch   = wr_data[CH_W-1:0];

  // next state, applied in the fixed order: read clear, write, tc, hold, release
  always_comb begin
    cmd_n  = cmd_q;
    mask_n = mask_q;
    stat_n = stat_q;
    tog_n  = tog_q ^ ptr_step;

    if (rd_en && (port == PORT_CMD)) begin
      stat_n[NCH-1:0] = '0;
    end

    if (wr_en) begin
      case (port)
        PORT_CMD: begin
          if ((wr_data & ~CMD_OK_BITS) == 8'h00) cmd_n = wr_data;
        end
        PORT_REQ: begin
          stat_n[NCH + int'(ch)] = wr_data[2];
          stat_n[int'(ch)]       = 1'b0;
        end
        PORT_MSK1:   mask_n[ch] = wr_data[2];
        PORT_MODE:   ;
        PORT_TOGCLR: tog_n = 1'b0;
        PORT_MCLR: begin
          tog_n  = 1'b0;
          mask_n = '1;
          stat_n = '0;
          cmd_n  = '0;
        end
        PORT_MSKCLR: mask_n = '0;
        PORT_MSKALL: mask_n = wr_data[NCH-1:0];
        default: ;
      endcase
    end

    stat_n[NCH-1:0]     = stat_n[NCH-1:0] | tc_pulse;
    stat_n[2*NCH-1:NCH] = stat_n[2*NCH-1:NCH] & ~tc_pulse;
    stat_n[2*NCH-1:NCH] = stat_n[2*NCH-1:NCH] | req_hold;
    stat_n[2*NCH-1:NCH] = stat_n[2*NCH-1:NCH] & ~req_release;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_n;
      mask_q <= mask_n;
      stat_q <= stat_n;
      tog_q  <= tog_n;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (port)
        PORT_CMD: rd_data = stat_q;
        PORT_REQ: rd_data = 8'(mask_q);
        default:  rd_data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/dmac_svc_pick.sv
module dmac_svc_pick
  import dmac_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int LEN_W = CNT_W + 2
)(
  input  logic [NCH-1:0]       mask_q,
  input  logic [NCH-1:0]       req_q,
  input  logic [NCH*CNT_W-1:0] base_cnt,
  input  logic                 word_mode,
  output logic                 svc_valid,
  output logic [CH_W-1:0]      svc_chan,
  output logic [LEN_W-1:0]     svc_len
);
  logic [NCH-1:0]   elig;
  logic [CNT_W-1:0] sel_base;
  logic [LEN_W-1:0] len_b;

  assign elig = ~mask_q & req_q;

  // descending scan so the lowest eligible channel is the last to assign
  always_comb begin
    svc_valid = 1'b0;
    svc_chan  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        svc_valid = 1'b1;
        svc_chan  = CH_W'(i);
      end
    end
  end

  assign sel_base = base_cnt[int'(svc_chan)*CNT_W +: CNT_W];
  assign len_b    = LEN_W'(sel_base) + LEN_W'(1);

  always_comb begin
    if (!svc_valid)     svc_len = '0;
    else if (word_mode) svc_len = len_b << 1;
    else                svc_len = len_b;
  end
endmodule

// File: rtl/dmac_ctrl_unit.sv
module dmac_ctrl_unit
  import dmac_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [2:0]           port_sel,
  input  logic [7:0]           wr_data,
  output logic [7:0]           rd_data,
  input  logic [NCH-1:0]       req_hold,
  input  logic [NCH-1:0]       req_release,
  input  logic [NCH-1:0]       tc_pulse,
  input  logic                 ptr_step,
  input  logic [NCH*CNT_W-1:0] base_cnt,
  input  logic                 word_mode,
  output logic [7:0]           cmd_value,
  output logic                 ptr_toggle,
  output logic [2*NCH-1:0]     mode_xfer,
  output logic [NCH-1:0]       mode_auto,
  output logic [NCH-1:0]       mode_dec,
  output logic [2*NCH-1:0]     mode_op,
  output logic                 svc_valid,
  output logic [CH_W-1:0]      svc_chan,
  output logic [CNT_W+1:0]     svc_len
);
  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic [NCH-1:0]   mask_w;
  logic [2*NCH-1:0] stat_w;
  logic             mode_we;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign mode_we = wr_en && (port_sel == PORT_MODE);

  dmac_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .port_sel(port_sel), .wr_data(wr_data), .req_hold(req_hold),
    .req_release(req_release), .tc_pulse(tc_pulse), .ptr_step(ptr_step),
    .rd_data(rd_data), .cmd_q(cmd_value), .mask_q(mask_w),
    .stat_q(stat_w), .tog_q(ptr_toggle)
  );

  dmac_mode_bank u_modes (
    .clk(clk), .rst_n(rst_sync_n), .mode_we(mode_we), .wr_data(wr_data),
    .mode_xfer(mode_xfer), .mode_auto(mode_auto), .mode_dec(mode_dec),
    .mode_op(mode_op)
  );

  dmac_svc_pick #(.CNT_W(CNT_W)) u_pick (
    .mask_q(mask_w), .req_q(stat_w[2*NCH-1:NCH]), .base_cnt(base_cnt),
    .word_mode(word_mode), .svc_valid(svc_valid), .svc_chan(svc_chan),
    .svc_len(svc_len)
  );
endmodule

// File: rtl/dmac_ctrl_chk.sv
module dmac_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] port_sel,
  input logic [7:0] wr_data,
  input logic [3:0] req_hold,
  input logic [3:0] req_release,
  input logic [3:0] tc_pulse,
  input logic [7:0] cmd_q,
  input logic [3:0] mask_q,
  input logic [7:0] stat_q,
  input logic       tog_q,
  input logic       svc_valid,
  input logic [1:0] svc_chan
);
  AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 3'd0 && (wr_data & 8'hFB) != 8'h00) |=> $stable(cmd_q)); // R1

  AST_SVC_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (!mask_q[svc_chan] && stat_q[{1'b1, svc_chan}])); // R9

  AST_SVC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (((~mask_q & stat_q[7:4]) & ((4'b0001 << svc_chan) - 4'b0001)) == 4'b0000)); // R9

  AST_SVC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_valid |-> ((~mask_q & stat_q[7:4]) == 4'b0000)); // R9

  AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 3'd5 && req_hold == 4'b0 && tc_pulse == 4'b0)
    |=> (mask_q == 4'hF && cmd_q == 8'h00 && !tog_q && stat_q == 8'h00)); // R6

  AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_release != 4'b0) |=> ((stat_q[7:4] & $past(req_release)) == 4'b0)); // R13

  AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse != 4'b0) |=> ((stat_q[3:0] & $past(tc_pulse)) == $past(tc_pulse))); // R10

  AST_RD_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && port_sel == 3'd0 && !wr_en && tc_pulse == 4'b0) |=> (stat_q[3:0] == 4'b0)); // R8
endmodule

bind dmac_ctrl_unit dmac_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
  .port_sel(port_sel), .wr_data(wr_data), .req_hold(req_hold),
  .req_release(req_release), .tc_pulse(tc_pulse), .cmd_q(cmd_value),
  .mask_q(mask_w), .stat_q(stat_w), .tog_q(ptr_toggle),
  .svc_valid(svc_valid), .svc_chan(svc_chan)
);

// File: tb/dmac_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module dmac_ctrl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, ptr_step, word_mode;
  logic [2:0]  port_sel;
  logic [7:0]  wr_data, rd_data, cmd_value;
  logic [3:0]  req_hold, req_release, tc_pulse, mode_auto, mode_dec;
  logic [63:0] base_cnt;
  logic        ptr_toggle, svc_valid;
  logic [7:0]  mode_xfer, mode_op;
  logic [1:0]  svc_chan;
  logic [17:0] svc_len;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic [7:0] m_cmd, m_stat;
  logic [3:0] m_mask;
  logic       m_tog;
  logic [7:0] m_mode [4];

  always #4 clk = ~clk;

  dmac_ctrl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .port_sel(port_sel), .wr_data(wr_data), .rd_data(rd_data),
    .req_hold(req_hold), .req_release(req_release), .tc_pulse(tc_pulse),
    .ptr_step(ptr_step), .base_cnt(base_cnt), .word_mode(word_mode),
    .cmd_value(cmd_value), .ptr_toggle(ptr_toggle), .mode_xfer(mode_xfer),
    .mode_auto(mode_auto), .mode_dec(mode_dec), .mode_op(mode_op),
    .svc_valid(svc_valid), .svc_chan(svc_chan), .svc_len(svc_len)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    if (!rd_en)              return 8'h00;
    if (port_sel == 3'd0)    return m_stat;
    if (port_sel == 3'd1)    return {4'h0, m_mask};
    return 8'h00;
  endfunction

  function automatic int exp_chan();
    for (int c = 0; c < 4; c++)
      if (!m_mask[c] && m_stat[4+c]) return c;
    return -1;
  endfunction

  function automatic logic [17:0] exp_len(input int c);
    logic [17:0] l;
    if (c < 0) return 18'h0;
    l = 18'(base_cnt[c*16 +: 16]) + 18'd1;
    return word_mode ? (l << 1) : l;
  endfunction

  // R13 ordering: read clear, write, tc, hold, release
  task automatic model_update();
    logic [7:0] s;
    int ch;
    s = m_stat;
    ch = int'(wr_data[1:0]);
    m_tog = m_tog ^ ptr_step;
    if (rd_en && port_sel == 3'd0) s[3:0] = 4'h0;
    if (wr_en) begin
      case (port_sel)
        3'd0: if ((wr_data & 8'hFB) == 8'h00) m_cmd = wr_data;
        3'd1: begin s[4+ch] = wr_data[2]; s[ch] = 1'b0; end
        3'd2: m_mask[ch] = wr_data[2];
        3'd3: m_mode[ch] = wr_data;
        3'd4: m_tog = 1'b0;
        3'd5: begin m_tog = 1'b0; m_mask = 4'hF; s = 8'h00; m_cmd = 8'h00; end
        3'd6: m_mask = 4'h0;
        default: m_mask = wr_data[3:0];
      endcase
    end
    s[3:0] = s[3:0] | tc_pulse;
    s[7:4] = (((s[7:4] & ~tc_pulse) | req_hold) & ~req_release);
    m_stat = s;
  endtask

  task automatic step(input string tag);
    logic [7:0] ex, eo;
    logic [3:0] ea, ed;
    int c;
    #1;
    chk(rd_data == exp_rd(), tag, "R8 rd_data", 32'(rd_data), 32'(exp_rd()));
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(cmd_value == m_cmd, tag, "R1 cmd_value", 32'(cmd_value), 32'(m_cmd));
    chk(ptr_toggle == m_tog, tag, "R5 ptr_toggle", 32'(ptr_toggle), 32'(m_tog));
    for (int k = 0; k < 4; k++) begin
      ex[2*k +: 2] = m_mode[k][3:2];
      eo[2*k +: 2] = m_mode[k][7:6];
      ea[k] = m_mode[k][4];
      ed[k] = m_mode[k][5];
    end
    chk({mode_xfer, mode_op, mode_auto, mode_dec} == {ex, eo, ea, ed}, tag, "R4 mode fields",
        {mode_xfer, mode_op, mode_auto, mode_dec}, {ex, eo, ea, ed});
    c = exp_chan();
    chk(svc_valid == (c >= 0), tag, "R9 svc_valid", 32'(svc_valid), 32'(c >= 0));
    if (c >= 0)
      chk(svc_chan == 2'(c), tag, "R9 svc_chan", 32'(svc_chan), 32'(c));
    chk(svc_len == exp_len(c), tag, "R11 svc_len", 32'(svc_len), 32'(exp_len(c)));
  endtask

  task automatic drive(input string tag, input bit w, input bit r, input logic [2:0] p,
                       input logic [7:0] d, input logic [3:0] h, input logic [3:0] rl,
                       input logic [3:0] t, input bit ps);
    wr_en = w; rd_en = r; port_sel = p; wr_data = d;
    req_hold = h; req_release = rl; tc_pulse = t; ptr_step = ps;
    step(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    wr_en = 0; rd_en = 0; port_sel = 0; wr_data = 0;
    req_hold = 0; req_release = 0; tc_pulse = 0; ptr_step = 0;
    base_cnt = {16'd40, 16'd30, 16'd20, 16'd10};
    word_mode = 1'b0;
    m_cmd = 0; m_stat = 0; m_mask = 4'hF; m_tog = 0;
    for (int k = 0; k < 4; k++) m_mode[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state through the read ports and outputs
    drive("R12", 0, 1, 3'd0, 8'h00, 0, 0, 0, 0);
    drive("R12", 0, 1, 3'd1, 8'h00, 0, 0, 0, 0);
    // R1 reject and accept
    drive("R1", 1, 0, 3'd0, 8'h01, 0, 0, 0, 0);
    drive("R1", 1, 0, 3'd0, 8'h04, 0, 0, 0, 0);
    drive("R1", 1, 0, 3'd0, 8'h84, 0, 0, 0, 0);
    drive("R1", 1, 0, 3'd0, 8'h00, 0, 0, 0, 0);
    // R7 clear mask, R2 request on channel 2
    drive("R7", 1, 0, 3'd6, 8'h00, 0, 0, 0, 0);
    drive("R2", 1, 0, 3'd1, 8'h06, 0, 0, 0, 0);
    // R10 hold channel 1 takes priority, R3 then masks it
    drive("R10", 0, 0, 3'd0, 8'h00, 4'b0010, 0, 0, 0);
    drive("R3", 1, 0, 3'd2, 8'h05, 0, 0, 0, 0);
    drive("R3", 0, 1, 3'd1, 8'h00, 0, 0, 0, 0);
    // R10 terminal count on channel 2
    drive("R10", 0, 0, 3'd0, 8'h00, 0, 0, 4'b0100, 0);
    drive("R8", 0, 1, 3'd0, 8'h00, 0, 0, 0, 0);
    drive("R8", 0, 1, 3'd0, 8'h00, 0, 0, 0, 0);
    // R2 request write clears the tc flag
    drive("R2", 0, 0, 3'd0, 8'h00, 0, 0, 4'b1000, 0);
    drive("R2", 1, 0, 3'd1, 8'h07, 0, 0, 0, 0);
    drive("R2", 0, 1, 3'd0, 8'h00, 0, 0, 0, 0);
    // R13 release beats hold; hold beats tc
    drive("R13", 0, 0, 3'd0, 8'h00, 4'b0001, 4'b0001, 0, 0);
    drive("R13", 0, 0, 3'd0, 8'h00, 4'b1000, 0, 4'b1000, 0);
    drive("R13", 0, 1, 3'd0, 8'h00, 0, 0, 4'b0001, 0);
    // R4 mode store on channel 3 and channel 0
    drive("R4", 1, 0, 3'd3, 8'hB7, 0, 0, 0, 0);
    drive("R4", 1, 0, 3'd3, 8'h5C, 0, 0, 0, 0);
    // R5 toggle step and clear, clear wins
    drive("R5", 0, 0, 3'd0, 8'h00, 0, 0, 0, 1);
    drive("R5", 1, 0, 3'd4, 8'h00, 0, 0, 0, 0);
    drive("R5", 0, 0, 3'd0, 8'h00, 0, 0, 0, 1);
    drive("R5", 1, 0, 3'd4, 8'h00, 0, 0, 0, 1);
    // R7 load mask, R11 word mode at maximum count
    drive("R7", 1, 0, 3'd7, 8'hF5, 0, 0, 0, 0);
    drive("R7", 0, 1, 3'd1, 8'h00, 0, 0, 0, 0);
    base_cnt = {4{16'hFFFF}};
    word_mode = 1'b1;
    drive("R11", 0, 0, 3'd0, 8'h00, 4'b1111, 0, 0, 0);
    word_mode = 1'b0;
    drive("R11", 0, 0, 3'd0, 8'h00, 0, 0, 0, 0);
    // R6 master clear keeps modes
    drive("R6", 1, 0, 3'd5, 8'h00, 0, 0, 0, 1);
    drive("R6", 0, 1, 3'd0, 8'h00, 0, 0, 0, 0);
    drive("R6", 0, 1, 3'd1, 8'h00, 0, 0, 0, 0);

    // random mix covering R1 through R13
    for (int i = 0; i < 3000; i++) begin
      base_cnt  = {$urandom, $urandom};
      word_mode = 1'($urandom);
      drive("rand",
            ($urandom % 10) < 3,
            ($urandom % 10) < 3,
            3'($urandom),
            8'(($urandom % 4 == 0) ? ($urandom & 32'h7) : $urandom),
            4'($urandom & $urandom & $urandom),
            4'($urandom & $urandom & $urandom),
            4'($urandom & $urandom & $urandom & $urandom),
            ($urandom % 5) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule